// File: doc/BRIEF.md
# PTP Event Timestamp Capture

This block records the local time at which a precision-time-protocol event frame crosses the start-of-frame point of the MAC. Each direction has a 64-bit capture slot. A capture happens in the same cycle as the start-of-frame strobe and stores the free-running time value `time_i`. The slot then holds its value, and refuses all later captures, until software reads the upper word. Software therefore always finds exactly one unambiguous timestamp, and it belongs to the frame that was marked.

On transmit, the MAC marks the frame that wants a stamp. On receive, the block classifies frames from header fields that an upstream parser has already extracted. It has two modes.

- A version-1 UDP mode accepts only the configured event port and a single selected message type.
- A version-2 event mode accepts every event message. These frames may arrive over UDP or at Layer 2, where an ethertype filter recognises them. Path-delay messages are included in this mode.

A one-cycle status pulse tags the received frame whose arrival time was stored, so it can be carried into that frame's descriptor.

Top module: `ptp_ts_capture`

## Requirements
- R1: After reset, the registers read as follows. TX_CTRL (addr 0) reads 0. RX_CTRL (addr 1) reads 0. RX_MSG (addr 2) reads 0x013F0000, which is event port 319 in bits [31:16] and message select 0 in bits [7:0]. L2_FLT (addr 3) reads 0x000088F7, which is filter enable in bit 31, stamp in bit 30 and ethertype in bits [15:0]. `rx_stamped_o` is 0.
- R2: TX_CTRL bit 0 is the enable and bit 1 is the read-only valid flag. When the enable is set and the slot is empty, a cycle with both `tx_sof_i` and `tx_ts_req_i` high stores that cycle's `time_i` and sets valid.
- R3: Each 64-bit capture reads as two 32-bit words. The transmit slot is at addresses 4 (low) and 5 (high). The receive slot is at addresses 6 (low) and 7 (high).
- R4: While a slot's valid flag is set, its stored value does not change, further qualifying frames are not stamped, and `rx_stamped_o` stays 0.
- R5: A read of the high word (address 5 or 7) clears that slot's valid flag and re-arms it for the next frame.
- R6: RX_CTRL bit 0 is the enable, bit 1 is the mode (0 = version-1 UDP) and bit 2 is the read-only valid flag. In mode 0, a receive frame qualifies only if all of the following hold:
  - it is UDP;
  - its destination port equals RX_MSG[31:16];
  - its version field is 1;
  - its 8-bit message field equals RX_MSG[7:0].
- R7: In mode 1, a receive frame qualifies only if both of the following hold:
  - its version is 2 and its message field bits [3:0] are an event type: 0 Sync, 1 Delay_Req, 2 Pdelay_Req or 3 Pdelay_Resp;
  - it is either UDP to the configured port, or it is accepted by the Layer-2 filter.
- R8: The Layer-2 filter accepts a non-UDP frame only when L2_FLT bit 31 and bit 30 are both set and the frame's ethertype equals L2_FLT[15:0].
- R9: `rx_stamped_o` is high for exactly the one cycle after the start-of-frame cycle of a received frame whose time was stored.
- R10: With a direction's enable bit clear, no frame is stamped in that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| time_i | input | 64 | Free-running time counter value |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effect on high words) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| tx_sof_i | input | 1 | Transmit start-of-frame cycle |
| tx_ts_req_i | input | 1 | Transmit frame requests a timestamp |
| rx_sof_i | input | 1 | Receive start-of-frame cycle, header fields valid |
| rx_is_udp_i | input | 1 | Frame carries UDP |
| rx_udp_dport_i | input | 16 | UDP destination port |
| rx_ethertype_i | input | 16 | Frame ethertype |
| rx_ptp_ver_i | input | 4 | PTP version field |
| rx_msg_i | input | 8 | Version-1 control field or version-2 message type |
| rx_stamped_o | output | 1 | Frame of previous SOF cycle was timestamped |

## Verification
Receive classification is tried with five kinds of frame:
- frames that match on every field;
- frames that differ in exactly one field: port, version, message value or ethertype;
- version-2 frames of the path-delay types, against a general message type;
- Layer-2 frames with the filter enable or stamp bit cleared;
- identical frames sent while a capture is pending, which separate the lock from the classifier.

Transmit is tried with the request strobe both present and absent, and with the enable both set and cleared. Reading back the captured time values distinguishes a stale capture from a fresh one. Because each capture uses a different time value, a second, unwanted capture shows up at the ports.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_TX_CTRL = 3'd0,
    A_RX_CTRL = 3'd1,
    A_RX_MSG  = 3'd2,
    A_L2_FLT  = 3'd3,
    A_TX_LO   = 3'd4,
    A_TX_HI   = 3'd5,
    A_RX_LO   = 3'd6,
    A_RX_HI   = 3'd7
  } reg_addr_e;

  typedef enum logic {
    MODE_V1_UDP   = 1'b0,
    MODE_V2_EVENT = 1'b1
  } rx_mode_e;

  typedef struct packed {
    logic        en;
    logic        ts;
    logic [15:0] etype;
  } l2_flt_t;

  localparam logic [15:0] EVENT_PORT_RST = 16'd319;
  localparam logic [15:0] PTP_ETYPE_RST  = 16'h88F7;
  localparam logic [3:0]  VER_1          = 4'd1;
  localparam logic [3:0]  VER_2          = 4'd2;
  localparam logic [3:0]  V2_LAST_EVENT  = 4'd3;

  localparam int unsigned SLOT_TX = 0;
  localparam int unsigned SLOT_RX = 1;
  localparam int unsigned N_SLOT  = 2;
endpackage

// File: rtl/ptp_rx_match.sv
module ptp_rx_match
  import ptp_ts_pkg::*;
(
  input  rx_mode_e    mode_i,
  input  logic [15:0] port_i,
  input  logic [7:0]  msg_sel_i,
  input  l2_flt_t     flt_i,
  input  logic        is_udp_i,
  input  logic [15:0] dport_i,
  input  logic [15:0] etype_i,
  input  logic [3:0]  ver_i,
  input  logic [7:0]  msg_i,
  output logic        match_o
);
  logic udp_hit, l2_hit, v1_hit, v2_hit;

  assign udp_hit = is_udp_i && (dport_i == port_i);
  assign l2_hit  = !is_udp_i && flt_i.en && flt_i.ts && (etype_i == flt_i.etype);
  assign v1_hit  = udp_hit && (ver_i == VER_1) && (msg_i == msg_sel_i);
  // path-delay types 2 and 3 are event messages too
  assign v2_hit  = (ver_i == VER_2) && (msg_i[3:0] <= V2_LAST_EVENT) && (udp_hit || l2_hit);

  always_comb begin
    unique case (mode_i)
      MODE_V1_UDP:   match_o = v1_hit;
      MODE_V2_EVENT: match_o = v2_hit;
      default:       match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptp_ts_slot.sv
module ptp_ts_slot #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              trig_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              rearm_i,
  output logic              capture_o,
  output logic              valid_o,
  output logic [TIME_W-1:0] ts_o
);
  logic              valid_q;
  logic [TIME_W-1:0] ts_q;

  assign capture_o = enable_i && trig_i && !valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ts_q    <= '0;
    end else if (capture_o) begin
      valid_q <= 1'b1;
      ts_q    <= time_i;
    end else if (rearm_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign ts_o    = ts_q;
endmodule

// File: rtl/ptp_ts_regs.sv
module ptp_ts_regs
  import ptp_ts_pkg::*;
#(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tx_valid_i,
  input  logic              rx_valid_i,
  input  logic [TIME_W-1:0] tx_ts_i,
  input  logic [TIME_W-1:0] rx_ts_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output rx_mode_e          rx_mode_o,
  output logic [15:0]       port_o,
  output logic [7:0]        msg_sel_o,
  output l2_flt_t           flt_o,
  output logic              tx_rearm_o,
  output logic              rx_rearm_o
);
  localparam int unsigned HI_W = TIME_W - REG_W;

  logic        tx_en_q, rx_en_q;
  rx_mode_e    mode_q;
  logic [15:0] port_q;
  logic [7:0]  msg_q;
  l2_flt_t     flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      mode_q  <= MODE_V1_UDP;
      port_q  <= EVENT_PORT_RST;
      msg_q   <= '0;
      flt_q   <= '{en: 1'b0, ts: 1'b0, etype: PTP_ETYPE_RST};
    end else if (we_i) begin
      unique case (addr_i)
        A_TX_CTRL: tx_en_q <= wdata_i[0];
        A_RX_CTRL: begin
          rx_en_q <= wdata_i[0];
          mode_q  <= rx_mode_e'(wdata_i[1]);
        end
        A_RX_MSG: begin
          port_q <= wdata_i[31:16];
          msg_q  <= wdata_i[7:0];
        end
        A_L2_FLT: flt_q <= '{en: wdata_i[31], ts: wdata_i[30], etype: wdata_i[15:0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_TX_CTRL: rdata_o = {30'd0, tx_valid_i, tx_en_q};
      A_RX_CTRL: rdata_o = {29'd0, rx_valid_i, mode_q, rx_en_q};
      A_RX_MSG:  rdata_o = {port_q, 8'd0, msg_q};
      A_L2_FLT:  rdata_o = {flt_q.en, flt_q.ts, 14'd0, flt_q.etype};
      A_TX_LO:   rdata_o = tx_ts_i[REG_W-1:0];
      A_TX_HI:   rdata_o = REG_W'(tx_ts_i[REG_W +: HI_W]);
      A_RX_LO:   rdata_o = rx_ts_i[REG_W-1:0];
      A_RX_HI:   rdata_o = REG_W'(rx_ts_i[REG_W +: HI_W]);
      default:   rdata_o = '0;
    endcase
  end

  assign tx_rearm_o = re_i && (addr_i == A_TX_HI);
  assign rx_rearm_o = re_i && (addr_i == A_RX_HI);
  assign tx_en_o    = tx_en_q;
  assign rx_en_o    = rx_en_q;
  assign rx_mode_o  = mode_q;
  assign port_o     = port_q;
  assign msg_sel_o  = msg_q;
  assign flt_o      = flt_q;
endmodule

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture
  import ptp_ts_pkg::*;
#(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              tx_sof_i,
  input  logic              tx_ts_req_i,
  input  logic              rx_sof_i,
  input  logic              rx_is_udp_i,
  input  logic [15:0]       rx_udp_dport_i,
  input  logic [15:0]       rx_ethertype_i,
  input  logic [3:0]        rx_ptp_ver_i,
  input  logic [7:0]        rx_msg_i,
  output logic              rx_stamped_o
);
  logic        tx_en, rx_en, rx_match;
  rx_mode_e    rx_mode;
  logic [15:0] port;
  logic [7:0]  msg_sel;
  l2_flt_t     flt;

  logic              slot_en    [N_SLOT];
  logic              slot_trig  [N_SLOT];
  logic              slot_rearm [N_SLOT];
  logic              slot_cap   [N_SLOT];
  logic              slot_valid [N_SLOT];
  logic [TIME_W-1:0] slot_ts    [N_SLOT];

  logic              tx_valid, rx_valid;
  logic [TIME_W-1:0] tx_ts, rx_ts;
  logic              tx_rearm, rx_rearm;
  logic              stamped_q;

  ptp_ts_regs #(.TIME_W(TIME_W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .re_i       (reg_re_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .tx_valid_i (tx_valid),
    .rx_valid_i (rx_valid),
    .tx_ts_i    (tx_ts),
    .rx_ts_i    (rx_ts),
    .tx_en_o    (tx_en),
    .rx_en_o    (rx_en),
    .rx_mode_o  (rx_mode),
    .port_o     (port),
    .msg_sel_o  (msg_sel),
    .flt_o      (flt),
    .tx_rearm_o (tx_rearm),
    .rx_rearm_o (rx_rearm)
  );

  ptp_rx_match match_i (
    .mode_i    (rx_mode),
    .port_i    (port),
    .msg_sel_i (msg_sel),
    .flt_i     (flt),
    .is_udp_i  (rx_is_udp_i),
    .dport_i   (rx_udp_dport_i),
    .etype_i   (rx_ethertype_i),
    .ver_i     (rx_ptp_ver_i),
    .msg_i     (rx_msg_i),
    .match_o   (rx_match)
  );

  assign slot_en[SLOT_TX]    = tx_en;
  assign slot_trig[SLOT_TX]  = tx_sof_i && tx_ts_req_i;
  assign slot_rearm[SLOT_TX] = tx_rearm;
  assign slot_en[SLOT_RX]    = rx_en;
  assign slot_trig[SLOT_RX]  = rx_sof_i && rx_match;
  assign slot_rearm[SLOT_RX] = rx_rearm;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    ptp_ts_slot #(.TIME_W(TIME_W)) slot_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .enable_i  (slot_en[g]),
      .trig_i    (slot_trig[g]),
      .time_i    (time_i),
      .rearm_i   (slot_rearm[g]),
      .capture_o (slot_cap[g]),
      .valid_o   (slot_valid[g]),
      .ts_o      (slot_ts[g])
    );
  end

  assign tx_valid = slot_valid[SLOT_TX];
  assign rx_valid = slot_valid[SLOT_RX];
  assign tx_ts    = slot_ts[SLOT_TX];
  assign rx_ts    = slot_ts[SLOT_RX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stamped_q <= 1'b0;
    else         stamped_q <= slot_cap[SLOT_RX];
  end

  assign rx_stamped_o = stamped_q;
endmodule

// File: rtl/ptp_ts_capture_chk.sv
module ptp_ts_capture_chk #(
  parameter int unsigned TIME_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_re_i,
  input logic [2:0]        reg_addr_i,
  input logic              tx_sof_i,
  input logic              tx_ts_req_i,
  input logic              rx_sof_i,
  input logic              rx_stamped_o,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic [TIME_W-1:0] tx_ts,
  input logic [TIME_W-1:0] rx_ts
);
  logic tx_hi_rd, rx_hi_rd;
  assign tx_hi_rd = reg_re_i && (reg_addr_i == 3'd5);
  assign rx_hi_rd = reg_re_i && (reg_addr_i == 3'd7);

  // R2
  tx_cap_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid) |-> $past(tx_sof_i && tx_ts_req_i));
  // R4
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid && !tx_hi_rd |=> tx_valid && $stable(tx_ts));
  // R4
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid && !rx_hi_rd |=> rx_valid && $stable(rx_ts));
  // R5
  rx_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid && rx_hi_rd |=> !rx_valid);
  // R5
  tx_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid && tx_hi_rd |=> !tx_valid);
  // R9
  stamp_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stamped_o |-> rx_valid && $past(rx_sof_i));
endmodule

bind ptp_ts_capture ptp_ts_capture_chk #(.TIME_W(TIME_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_re_i     (reg_re_i),
  .reg_addr_i   (reg_addr_i),
  .tx_sof_i     (tx_sof_i),
  .tx_ts_req_i  (tx_ts_req_i),
  .rx_sof_i     (rx_sof_i),
  .rx_stamped_o (rx_stamped_o),
  .tx_valid     (tx_valid),
  .rx_valid     (rx_valid),
  .tx_ts        (tx_ts),
  .rx_ts        (rx_ts)
);

// File: tb/ptp_ts_capture_tb.sv
module ptp_ts_capture_tb_top;
  localparam int CLK_NS = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] time_i = '0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        tx_sof_i = 1'b0, tx_ts_req_i = 1'b0;
  logic        rx_sof_i = 1'b0, rx_is_udp_i = 1'b0;
  logic [15:0] rx_udp_dport_i = '0, rx_ethertype_i = '0;
  logic [3:0]  rx_ptp_ver_i = '0;
  logic [7:0]  rx_msg_i = '0;
  logic        rx_stamped_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  ptp_ts_capture dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic rd_ts(input logic [2:0] lo, output logic [63:0] ts);
    logic [31:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    ts = {h, l};
  endtask

  task automatic tx_frame(input logic req, input logic [63:0] t);
    @(negedge clk_i);
    tx_sof_i = 1'b1; tx_ts_req_i = req; time_i = t;
    @(negedge clk_i);
    tx_sof_i = 1'b0; tx_ts_req_i = 1'b0;
  endtask

  task automatic rx_frame(input logic udp, input logic [15:0] port, input logic [15:0] et,
                          input logic [3:0] ver, input logic [7:0] msg,
                          input logic [63:0] t, output logic stamped);
    @(negedge clk_i);
    rx_sof_i = 1'b1; rx_is_udp_i = udp; rx_udp_dport_i = port;
    rx_ethertype_i = et; rx_ptp_ver_i = ver; rx_msg_i = msg; time_i = t;
    @(negedge clk_i);
    rx_sof_i = 1'b0;
    stamped = rx_stamped_o;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 stamped", {63'd0, rx_stamped_o}, 64'd0);
    rd(3'd0, d); check("R1 tx_ctrl", {32'd0, d}, 64'd0);
    rd(3'd1, d); check("R1 rx_ctrl", {32'd0, d}, 64'd0);
    rd(3'd2, d); check("R1 rx_msg", {32'd0, d}, 64'h013F0000);
    rd(3'd3, d); check("R1 l2_flt", {32'd0, d}, 64'h000088F7);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    logic [63:0] ts;
    wr(3'd0, 32'd1);
    tx_frame(1'b1, 64'h1122334455667788);
    rd(3'd0, d); check("R2 tx valid set", {32'd0, d}, 64'd3);
    tx_frame(1'b1, 64'hAAAABBBBCCCCDDDD);
    rd_ts(3'd4, ts); check("R3/R4 tx ts held", ts, 64'h1122334455667788);
    rd(3'd0, d); check("R5 tx valid cleared", {32'd0, d}, 64'd1);
    tx_frame(1'b0, 64'h5);
    rd(3'd0, d); check("R2 no request no capture", {32'd0, d}, 64'd1);
    tx_frame(1'b1, 64'h77);
    rd_ts(3'd4, ts); check("R5 tx re-armed", ts, 64'h77);
    wr(3'd0, 32'd0);
    tx_frame(1'b1, 64'h99);
    rd(3'd0, d); check("R10 tx disabled", {32'd0, d}, 64'd0);
  endtask

  task automatic t_rx_v1();
    logic s;
    logic [31:0] d;
    logic [63:0] ts;
    wr(3'd1, 32'd1);
    rx_frame(1, 16'd319, 16'h0800, 4'd1, 8'd0, 64'h100, s); check("R6/R9 v1 sync stamped", {63'd0, s}, 64'd1);
    rx_frame(1, 16'd319, 16'h0800, 4'd1, 8'd0, 64'h200, s); check("R4 locked no stamp", {63'd0, s}, 64'd0);
    rd(3'd1, d); check("R6 rx ctrl valid", {32'd0, d}, 64'd5);
    rd_ts(3'd6, ts); check("R3/R4 rx ts", ts, 64'h100);
    rd(3'd1, d); check("R5 rx valid cleared", {32'd0, d}, 64'd1);
    rx_frame(1, 16'd319, 16'h0800, 4'd1, 8'd1, 64'h210, s); check("R6 other msg type", {63'd0, s}, 64'd0);
    rx_frame(1, 16'd320, 16'h0800, 4'd1, 8'd0, 64'h220, s); check("R6 wrong port", {63'd0, s}, 64'd0);
    rx_frame(1, 16'd319, 16'h0800, 4'd2, 8'd0, 64'h230, s); check("R6 v2 in v1 mode", {63'd0, s}, 64'd0);
    rx_frame(0, 16'd319, 16'h88F7, 4'd1, 8'd0, 64'h240, s); check("R6 non-udp in v1 mode", {63'd0, s}, 64'd0);
    wr(3'd2, 32'h013F0001);
    rx_frame(1, 16'd319, 16'h0800, 4'd1, 8'd1, 64'h300, s); check("R6 delay_req selected", {63'd0, s}, 64'd1);
    rd_ts(3'd6, ts); check("R6 delay_req ts", ts, 64'h300);
  endtask

  task automatic t_rx_v2();
    logic s;
    logic [31:0] d;
    logic [63:0] ts;
    wr(3'd1, 32'd3);
    rd(3'd1, d); check("R7 mode readback", {32'd0, d}, 64'd3);
    rx_frame(1, 16'd319, 16'h0800, 4'd2, 8'd2, 64'h400, s); check("R7 pdelay_req stamped", {63'd0, s}, 64'd1);
    rd_ts(3'd6, ts); check("R7 pdelay ts", ts, 64'h400);
    rx_frame(1, 16'd319, 16'h0800, 4'd2, 8'd8, 64'h410, s); check("R7 general msg rejected", {63'd0, s}, 64'd0);
    rx_frame(1, 16'd319, 16'h0800, 4'd1, 8'd0, 64'h420, s); check("R7 v1 in v2 mode", {63'd0, s}, 64'd0);
    rx_frame(1, 16'd319, 16'h0800, 4'd2, 8'd3, 64'h430, s); check("R7 pdelay_resp stamped", {63'd0, s}, 64'd1);
    rd_ts(3'd6, ts);
    rx_frame(0, 16'd0, 16'h88F7, 4'd2, 8'd0, 64'h500, s); check("R8 filter off", {63'd0, s}, 64'd0);
    wr(3'd3, 32'hC00088F7);
    rx_frame(0, 16'd0, 16'h88F7, 4'd2, 8'd0, 64'h510, s); check("R8 L2 stamped", {63'd0, s}, 64'd1);
    rd_ts(3'd6, ts); check("R8 L2 ts", ts, 64'h510);
    rx_frame(0, 16'd0, 16'h88F8, 4'd2, 8'd0, 64'h520, s); check("R8 wrong ethertype", {63'd0, s}, 64'd0);
    wr(3'd3, 32'h800088F7);
    rx_frame(0, 16'd0, 16'h88F7, 4'd2, 8'd0, 64'h530, s); check("R8 stamp bit clear", {63'd0, s}, 64'd0);
    wr(3'd1, 32'd2);
    rx_frame(1, 16'd319, 16'h0800, 4'd2, 8'd0, 64'h540, s); check("R10 rx disabled", {63'd0, s}, 64'd0);
    rd(3'd1, d); check("R10 rx no valid", {32'd0, d}, 64'd2);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_tx();
    t_rx_v1();
    t_rx_v2();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule